// File: doc/BRIEF.md
# Line Buffer Configuration Selector

This block chooses how the line-buffer memory of a vertical scaler is split up. Software or a sequencer supplies the luma and chroma line widths (already reduced to the smaller of viewport and output width), a bits-per-component code, the luma and chroma vertical tap counts, the rounded-up vertical scale ratios, and three flags: alpha enable, 4:2:0 format and force-max. A single-cycle start pulse launches a search.

The search tries fixed memory configurations in a set order. For each one it derives how many whole lines (partitions) fit for luma and chroma, applies the alpha limit and the cap, and checks the tap-count rule. The first configuration that passes is reported, with its two partition counts. All divisions go through one shared restoring divider, so every search takes a bounded number of cycles.

A one-cycle done pulse marks the result. The outputs hold their values until the next result replaces them.

Top module: `lbsel_top`

## Requirements
- R1: Line size in 72-bit memory words is ceil(width*bpc/72) for luma and chroma, and ceil(width_y/6) for alpha. A width of 0 is treated as 1.
- R2: The memory sizes (luma/chroma/alpha) are: config 1 = 816/816/984, config 2 = 1088/1088/1312, config 3 = 4448/1904/2752, config 0 = 2752/2752/2752. The `cfg` output carries the configuration number in binary.
- R3: The raw partition count is the memory size divided by the line words, truncated. When alpha is enabled and the alpha count is smaller, the luma count is lowered to the alpha count. Both reported counts are capped at 64.
- R4: A configuration passes when, for luma and for chroma, taps <= partitions - ratio + 2 if ratio > 2, and taps <= partitions otherwise.
- R5: The search order is config 1, then config 2, then config 3 (tried only when `fmt420` is 1), then config 0. The first passing configuration is the result.
- R6: With `force_max` set, config 0 is the only candidate, whatever the other inputs are.
- R7: The `bpc_code` encoding is 0 = 10 bits, 1 = 8 bits, 2 = 6 bits, 3 = 12 bits.
- R8: `err` is 1 exactly when config 0 is the result and it fails the R4 rule. The reported counts are still config 0's counts.
- R9: `done` is high for exactly one cycle per search. `cfg`, `parts_y`, `parts_c` and `err` change only in the cycle in which `done` is high. A start pulse while `busy` is high is ignored.
- R10: `done` rises no more than 400 clock cycles after the start pulse is accepted. After reset, `done`, `busy` and `err` are 0, `cfg` is 0 and both counts are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when idle |
| width_y | input | WW | Luma line width in pixels |
| width_c | input | WW | Chroma line width in pixels |
| bpc_code | input | 2 | Bits-per-component code (R7) |
| taps_y | input | TW | Luma vertical taps |
| taps_c | input | TW | Chroma vertical taps |
| ratio_y | input | TW | Luma ceil(vertical ratio) |
| ratio_c | input | TW | Chroma ceil(vertical ratio) |
| alpha_en | input | 1 | Alpha plane stored |
| fmt420 | input | 1 | Source is 4:2:0 |
| force_max | input | 1 | Use config 0 directly |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| cfg | output | 2 | Chosen configuration |
| parts_y | output | 7 | Luma partitions |
| parts_c | output | 7 | Chroma partitions |
| err | output | 1 | Config 0 failed the tap rule |

## Verification
A wrong stored line-word count or a wrong divider quotient shows up as a wrong partition count on the next done pulse, and often as a different configuration. A search pointer that skips a candidate, or that visits config 3 without 4:2:0, returns a configuration number that the first-fit model does not accept. A stuck control state shows as a missing done pulse within the 400-cycle bound. Random cases cover many width, depth and tap combinations. Directed cases target the cap, the alpha limit, the ratio rule, force-max, zero width and the error fallback.

// File: rtl/lbsel_pkg.sv
package lbsel_pkg;

    localparam int WW   = 14;          // width input bits
    localparam int TW   = 4;           // tap / ratio input bits
    localparam int DW   = WW + 4;      // divider operand bits
    localparam int PW   = 7;           // partition output bits
    localparam int PCAP = 64;          // partition cap

    typedef enum logic [1:0] {
        CFG_MAX = 2'd0, CFG_SMALL = 2'd1, CFG_MID = 2'd2, CFG_420 = 2'd3
    } lb_cfg_e;

    typedef enum logic [1:0] { K_Y = 2'd0, K_C = 2'd1, K_A = 2'd2 } lb_kind_e;

    typedef struct packed {
        logic [WW-1:0] wy;
        logic [WW-1:0] wc;
        logic [1:0]    bpc_code;
        logic [TW-1:0] ty;
        logic [TW-1:0] tc;
        logic [TW-1:0] ry;
        logic [TW-1:0] rc;
        logic          alpha;
        logic          f420;
        logic          fmax;
    } lb_req_t;

    function automatic logic [3:0] bpc_of(input logic [1:0] code);
        case (code)
            2'd0: return 4'd10;
            2'd1: return 4'd8;
            2'd2: return 4'd6;
            default: return 4'd12;
        endcase
    endfunction

    function automatic logic [12:0] mem_size(input lb_cfg_e c, input lb_kind_e k);
        case (c)
            CFG_SMALL: return (k == K_A) ? 13'd984  : 13'd816;
            CFG_MID:   return (k == K_A) ? 13'd1312 : 13'd1088;
            CFG_420:   return (k == K_Y) ? 13'd4448 : (k == K_C) ? 13'd1904 : 13'd2752;
            default:   return 13'd2752;
        endcase
    endfunction

    function automatic logic tap_fits(input logic [TW-1:0] taps,
                                      input logic [TW-1:0] ratio,
                                      input logic [PW-1:0] parts);
        if (ratio > 2)
            return ({4'd0, taps} + {4'd0, ratio}) <= ({1'b0, parts} + 8'd2);
        return {3'd0, taps} <= parts;
    endfunction

endpackage

// File: rtl/lbsel_divider.sv
module lbsel_divider
    import lbsel_pkg::*;
#(
    parameter int N = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [N-1:0] num,
    input  logic [N-1:0] den,
    output logic [N-1:0] quo,
    output logic         valid
);
    localparam int CW = $clog2(N + 1);

    logic [N-1:0]  rem_q, quo_q, num_q, den_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q, valid_q;
    logic [N:0]    shifted, trial;
    logic          fits;

    always_comb begin
        shifted = {rem_q, quo_q[N-1]};
        trial   = shifted - {1'b0, den_q};
        fits    = shifted >= {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0; quo_q <= '0; num_q <= '0; den_q <= '0;
            cnt_q <= '0; busy_q <= 1'b0; valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (go) begin
                rem_q  <= '0;
                quo_q  <= num;
                num_q  <= num;
                den_q  <= den;
                cnt_q  <= CW'(N);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= fits ? trial[N-1:0] : shifted[N-1:0];
                quo_q <= {quo_q[N-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy_q  <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign quo   = quo_q;
    assign valid = valid_q;

    logic [2*N:0] prod_lo, prod_hi;
    assign prod_lo = quo_q * den_q;
    assign prod_hi = prod_lo + den_q;

    // R3
    quotient_range_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (prod_lo <= {{(N+1){1'b0}}, num_q}) && ({{(N+1){1'b0}}, num_q} < prod_hi));

    // R1
    nonzero_den_chk: assert property (@(posedge clk) disable iff (rst)
        go |-> (den != '0));

endmodule

// File: rtl/lbsel_fit.sv
module lbsel_fit
    import lbsel_pkg::*;
(
    input  logic [DW-1:0] raw_y,
    input  logic [DW-1:0] raw_c,
    input  logic [DW-1:0] raw_a,
    input  logic          alpha,
    input  logic [TW-1:0] ty,
    input  logic [TW-1:0] tc,
    input  logic [TW-1:0] ry,
    input  logic [TW-1:0] rc,
    output logic [PW-1:0] part_y,
    output logic [PW-1:0] part_c,
    output logic          ok
);
    logic [DW-1:0] lim_y;

    always_comb begin
        lim_y  = (alpha && raw_a < raw_y) ? raw_a : raw_y;
        part_y = (lim_y > DW'(PCAP)) ? PW'(PCAP) : lim_y[PW-1:0];
        part_c = (raw_c > DW'(PCAP)) ? PW'(PCAP) : raw_c[PW-1:0];
        ok     = tap_fits(ty, ry, part_y) && tap_fits(tc, rc, part_c);
    end

    // R3
    always_comb cap_bound_chk: assert (part_y <= PW'(PCAP) && part_c <= PW'(PCAP));

endmodule

// File: rtl/lbsel_top.sv
module lbsel_top
    import lbsel_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [WW-1:0] width_y,
    input  logic [WW-1:0] width_c,
    input  logic [1:0]    bpc_code,
    input  logic [TW-1:0] taps_y,
    input  logic [TW-1:0] taps_c,
    input  logic [TW-1:0] ratio_y,
    input  logic [TW-1:0] ratio_c,
    input  logic          alpha_en,
    input  logic          fmt420,
    input  logic          force_max,
    output logic          busy,
    output logic          done,
    output logic [1:0]    cfg,
    output logic [PW-1:0] parts_y,
    output logic [PW-1:0] parts_c,
    output logic          err
);
    typedef enum logic [1:0] { S_IDLE, S_ISSUE, S_WAIT, S_EVAL } st_e;

    st_e           st_q;
    lb_req_t       req_q;
    lb_cfg_e       cur_q;
    logic [2:0]    op_q;
    logic [DW-1:0] wd_y, wd_c, wd_a, rw_y, rw_c, rw_a;
    logic [DW-1:0] div_num, div_den, div_quo;
    logic          div_valid;
    logic [DW-1:0] ey, ec;
    logic [PW-1:0] fit_y, fit_c;
    logic          fit_ok;
    lb_cfg_e       nxt_cfg;

    always_comb begin
        ey = (req_q.wy == '0) ? DW'(1) : DW'(req_q.wy);
        ec = (req_q.wc == '0) ? DW'(1) : DW'(req_q.wc);
        case (op_q)
            3'd0:    begin div_num = ey * DW'(bpc_of(req_q.bpc_code)) + DW'(71); div_den = DW'(72); end
            3'd1:    begin div_num = ec * DW'(bpc_of(req_q.bpc_code)) + DW'(71); div_den = DW'(72); end
            3'd2:    begin div_num = ey + DW'(5); div_den = DW'(6); end
            3'd3:    begin div_num = DW'(mem_size(cur_q, K_Y)); div_den = wd_y; end
            3'd4:    begin div_num = DW'(mem_size(cur_q, K_C)); div_den = wd_c; end
            default: begin div_num = DW'(mem_size(cur_q, K_A)); div_den = wd_a; end
        endcase
        case (cur_q)
            CFG_SMALL: nxt_cfg = CFG_MID;
            CFG_MID:   nxt_cfg = req_q.f420 ? CFG_420 : CFG_MAX;
            default:   nxt_cfg = CFG_MAX;
        endcase
    end

    lbsel_divider #(.N(DW)) div_i (
        .clk(clk), .rst(rst), .go(st_q == S_ISSUE),
        .num(div_num), .den(div_den), .quo(div_quo), .valid(div_valid)
    );

    lbsel_fit fit_i (
        .raw_y(rw_y), .raw_c(rw_c), .raw_a(rw_a), .alpha(req_q.alpha),
        .ty(req_q.ty), .tc(req_q.tc), .ry(req_q.ry), .rc(req_q.rc),
        .part_y(fit_y), .part_c(fit_c), .ok(fit_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= S_IDLE; req_q <= '0; cur_q <= CFG_MAX; op_q <= '0;
            wd_y <= '0; wd_c <= '0; wd_a <= '0; rw_y <= '0; rw_c <= '0; rw_a <= '0;
            busy <= 1'b0; done <= 1'b0; cfg <= '0; parts_y <= '0; parts_c <= '0; err <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                S_IDLE: if (start) begin
                    req_q <= '{wy: width_y, wc: width_c, bpc_code: bpc_code,
                               ty: taps_y, tc: taps_c, ry: ratio_y, rc: ratio_c,
                               alpha: alpha_en, f420: fmt420, fmax: force_max};
                    cur_q <= force_max ? CFG_MAX : CFG_SMALL;
                    op_q  <= 3'd0;
                    busy  <= 1'b1;
                    st_q  <= S_ISSUE;
                end
                S_ISSUE: st_q <= S_WAIT;
                S_WAIT: if (div_valid) begin
                    case (op_q)
                        3'd0: wd_y <= div_quo;
                        3'd1: wd_c <= div_quo;
                        3'd2: wd_a <= div_quo;
                        3'd3: rw_y <= div_quo;
                        3'd4: rw_c <= div_quo;
                        default: rw_a <= div_quo;
                    endcase
                    if (op_q == 3'd5) st_q <= S_EVAL;
                    else begin op_q <= op_q + 3'd1; st_q <= S_ISSUE; end
                end
                default: begin
                    if (fit_ok || cur_q == CFG_MAX) begin
                        cfg     <= cur_q;
                        parts_y <= fit_y;
                        parts_c <= fit_c;
                        err     <= !fit_ok;
                        done    <= 1'b1;
                        busy    <= 1'b0;
                        st_q    <= S_IDLE;
                    end else begin
                        cur_q <= nxt_cfg;
                        op_q  <= 3'd3;
                        st_q  <= S_ISSUE;
                    end
                end
            endcase
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(cfg) && $stable(parts_y) && $stable(parts_c) && $stable(err));

    // R8
    err_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (cfg == 2'd0));

    // R5
    cfg420_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        (done && cfg == 2'd3) |-> req_q.f420);

    // R6
    force_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (done && req_q.fmax) |-> (cfg == 2'd0));

    // R4
    pass_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (tap_fits(req_q.ty, req_q.ry, parts_y) && tap_fits(req_q.tc, req_q.rc, parts_c)));

endmodule

// File: tb/lbsel_top_tb_top.sv
module lbsel_top_tb_top;
    import lbsel_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [WW-1:0] width_y = '0, width_c = '0;
    logic [1:0] bpc_code = '0;
    logic [TW-1:0] taps_y = '0, taps_c = '0, ratio_y = '0, ratio_c = '0;
    logic alpha_en = 1'b0, fmt420 = 1'b0, force_max = 1'b0;
    logic busy, done, err;
    logic [1:0] cfg;
    logic [PW-1:0] parts_y, parts_c;

    int checks = 0;
    int fails  = 0;
    bit timed_out = 0;

    always #2 clk = ~clk;  // 250 MHz

    lbsel_top dut_i (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int msize(input int c, input int k);
        int t [4][3] = '{'{2752, 2752, 2752}, '{816, 816, 984},
                         '{1088, 1088, 1312}, '{4448, 1904, 2752}};
        return t[c][k];
    endfunction

    function automatic bit rule(input int t, input int r, input int p);
        if (r > 2) return t <= p - r + 2;
        return t <= p;
    endfunction

    function automatic void model(input int wy, input int wc, input int bc, input int ty,
                                  input int tc, input int ry, input int rc, input bit al,
                                  input bit f4, input bit fm,
                                  output int ecfg, output int epy, output int epc, output int eerr);
        int bpc, ly, lc, la, py, pc, pa;
        int order [4];
        int n;
        bpc = (bc == 0) ? 10 : (bc == 1) ? 8 : (bc == 2) ? 6 : 12;
        if (wy == 0) wy = 1;
        if (wc == 0) wc = 1;
        ly = (wy * bpc + 71) / 72;
        lc = (wc * bpc + 71) / 72;
        la = (wy + 5) / 6;
        n = 0;
        if (!fm) begin
            order[n++] = 1; order[n++] = 2;
            if (f4) order[n++] = 3;
        end
        order[n++] = 0;
        for (int i = 0; i < n; i++) begin
            py = msize(order[i], 0) / ly;
            pc = msize(order[i], 1) / lc;
            pa = msize(order[i], 2) / la;
            if (al && pa < py) py = pa;
            if (py > 64) py = 64;
            if (pc > 64) pc = 64;
            ecfg = order[i]; epy = py; epc = pc;
            eerr = !(rule(ty, ry, py) && rule(tc, rc, pc));
            if (!eerr) return;
        end
    endfunction

    task automatic run(input string tag, input int wy, input int wc, input int bc, input int ty,
                       input int tc, input int ry, input int rc, input bit al,
                       input bit f4, input bit fm, input bit poke);
        int ecfg, epy, epc, eerr, lat;
        model(wy, wc, bc, ty, tc, ry, rc, al, f4, fm, ecfg, epy, epc, eerr);
        @(negedge clk);
        width_y = WW'(wy); width_c = WW'(wc); bpc_code = 2'(bc);
        taps_y = TW'(ty); taps_c = TW'(tc); ratio_y = TW'(ry); ratio_c = TW'(rc);
        alpha_en = al; fmt420 = f4; force_max = fm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        if (poke) begin
            // R9: start while busy must be ignored
            repeat (5) @(negedge clk);
            width_y = 16383; taps_y = 8; force_max = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat += 6;
        end
        while (!done && lat < 1000) begin @(negedge clk); lat++; end
        // R10
        check({tag, " R10 latency"}, (lat <= 400) ? 1 : 0, 1);
        check({tag, " R5 cfg"}, int'(cfg), ecfg);
        check({tag, " R3 parts_y"}, int'(parts_y), epy);
        check({tag, " R3 parts_c"}, int'(parts_c), epc);
        check({tag, " R8 err"}, int'(err), eerr);
        @(negedge clk);
        check({tag, " R9 done one cycle"}, int'(done), 0);
        repeat (3) @(negedge clk);
        check({tag, " R9 hold cfg"}, int'(cfg), ecfg);
        check({tag, " R9 hold parts_y"}, int'(parts_y), epy);
    endtask

    initial begin
        #1000000;
        timed_out = 1;
        fails++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 reset done", int'(done), 0);
        check("R10 reset busy", int'(busy), 0);
        check("R10 reset err", int'(err), 0);
        check("R10 reset cfg", int'(cfg), 0);
        check("R10 reset parts", int'(parts_y) + int'(parts_c), 0);

        // R1 zero width treated as 1, R3 cap at 64
        run("zero_width R1", 0, 0, 3, 4, 4, 1, 1, 0, 0, 0, 0);
        // R2/R5 config 3 chosen for 4:2:0
        run("pick420 R2", 4096, 2048, 3, 4, 4, 1, 1, 0, 1, 0, 0);
        // R5 same without 4:2:0 falls to config 0
        run("no420 R5", 4096, 2048, 3, 4, 4, 1, 1, 0, 0, 0, 0);
        // R8 even config 0 fails
        run("fail R8", 16383, 16383, 3, 8, 8, 1, 1, 0, 1, 0, 0);
        // R6 force max on an easy case
        run("force R6", 100, 50, 1, 2, 2, 1, 1, 0, 0, 1, 0);
        // R3 alpha limit
        run("alpha R3", 2000, 1000, 2, 3, 3, 1, 1, 1, 0, 0, 0);
        // R4 ratio above 2 rule
        run("ratio R4", 1920, 960, 0, 4, 4, 4, 4, 0, 0, 0, 0);
        run("ratio2 R4", 1920, 960, 0, 4, 4, 2, 2, 0, 0, 0, 0);
        // R7 each depth code
        for (int b = 0; b < 4; b++) run("bpc R7", 3840, 1920, b, 4, 4, 1, 1, 0, 1, 0, 0);
        // R9 start while busy ignored
        run("busy_start R9", 1280, 640, 1, 3, 3, 1, 1, 0, 0, 0, 1);

        for (int i = 0; i < 60; i++) begin
            run("rand R1", int'($urandom_range(0, 16383)), int'($urandom_range(0, 8191)),
                int'($urandom_range(0, 3)), int'($urandom_range(1, 8)), int'($urandom_range(1, 8)),
                int'($urandom_range(1, 4)), int'($urandom_range(1, 4)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0), 0);
        end

        if (!timed_out) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule